// File: doc/BRIEF.md
# DMA Request Pulse Generator

This block drives one request pin toward an external DMA controller. A three-bit control register, written and read by the processor over a plain synchronous register port, holds a mode bit, a polarity bit and a trigger bit. The pin's active level depends on the polarity bit. The trigger bit decides whether the request is currently asserted.

In edge mode, writing 1 to the trigger starts a timed pulse. The pin asserts on the clock edge that takes the write and stays asserted for a fixed number of cycles. The trigger bit reads back as 1 for the whole pulse and drops on the same edge at which the pin negates. In level mode there is no timer, and the request simply follows the trigger bit until software writes it back to 0. Changing the polarity moves the pin to the new level on the edge that takes the write, whether the block is idle or a pulse is running. The block has no data path, so it has no valid/ready stream interface and no back-pressure rules. Every pin is a plain control or status signal.

Top module: `dreq_pulse_gen`

## Requirements
- R1: After reset, the register reads 3'b000 and the request pin is high, which is the negated level for polarity 0.
- R2: The field layout is bit 0 = trigger, bit 1 = polarity, bit 2 = mode (1 = edge, 0 = level). A read returns the current register state, including the live trigger, with no added latency.
- R3: In edge mode with polarity 0, a write with bit 0 set drives the pin low on the clock edge that takes the write.
- R4: An edge-mode pulse lasts exactly PULSE_LEN cycles (32 by default). The trigger bit reads 1 for exactly those cycles and reads 0 on the same edge at which the pin negates.
- R5: Writing polarity 1 while idle drives the pin low on the edge that takes the write. A pulse under polarity 1 drives the pin high.
- R6: In edge mode, writing 1 to the trigger while a pulse is running neither restarts nor extends that pulse.
- R7: In edge mode, writing 0 to the trigger bit has no effect on a running pulse or on the pin.
- R8: In level mode, the pin stays asserted while the trigger is 1, beyond any pulse length, until a write of 0 to the trigger negates it on that write's edge.
- R9: A polarity change during a pulse moves the pin to the new active level on the edge that takes the write. The total pulse length is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising clock edge |
| reg_wdata | input | 3 | Write data: bit 2 mode, bit 1 polarity, bit 0 trigger |
| reg_rdata | output | 3 | Current register value, same layout as the write data |
| dreq_o | output | 1 | DMA request pin |

## Verification
Every result is due one edge after its cause. A write sampled at edge E changes the register readback and the pin by the next falling edge. A pulse started at E negates at E+PULSE_LEN, so the pin shows the active level on exactly PULSE_LEN falling-edge samples. The bench drives inputs and samples outputs only on falling edges. It counts active samples one per cycle from the first sample after the write, and it checks trigger readback on the first negated sample. Mid-pulse writes are issued at a chosen sample index, so their effect is checked on the following sample.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  localparam int CTRL_W   = 3;
  localparam int TRIG_BIT = 0;
  localparam int POL_BIT  = 1;
  localparam int MODE_BIT = 2;

  // Packed so that field order matches the register bit positions.
  typedef struct packed {
    logic mode;  // bit 2: 1 = timed edge pulse, 0 = level
    logic pol;   // bit 1: active level of the request
    logic trig;  // bit 0: request trigger
  } ctrl_t;
endpackage

// File: rtl/dreq_ctrl_regs.sv
module dreq_ctrl_regs
  import dreq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  ctrl_t wdata,
  input  logic  done,
  output ctrl_t cur,
  output ctrl_t nxt,
  output logic  start
);
  logic lvl_clear;

  assign lvl_clear = wr && !wdata.trig && !wdata.mode;

  always_comb begin
    nxt = cur;
    if (wr) begin
      nxt.mode = wdata.mode;
      nxt.pol  = wdata.pol;
      if (wdata.trig)
        nxt.trig = 1'b1;
      else if (!wdata.mode)
        nxt.trig = 1'b0;
    end
    if (done)
      nxt.trig = 1'b0;
  end

  // A timed pulse begins when the edge-mode request turns on.
  assign start = nxt.trig && nxt.mode && !(cur.trig && cur.mode);

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  AST_TRIG_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cur.trig) |-> ($past(done) || $past(lvl_clear)));  // R7
endmodule

// File: rtl/dreq_pulse_timer.sv
module dreq_pulse_timer #(
  parameter int PULSE_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CNT_W = $clog2(PULSE_LEN) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LEN - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= LAST;
    else if (run && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == '0);

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == LAST));  // R4
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);  // R4
  AST_NO_LOAD_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && run));  // R6
endmodule

// File: rtl/dreq_pin_drive.sv
module dreq_pin_drive (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_nxt,
  input  logic pol_nxt,
  output logic pin
);
  // Asserted level equals polarity; negated level is its inverse.
  always_ff @(posedge clk) begin
    if (!rst_n) pin <= 1'b1;
    else        pin <= trig_nxt ? pol_nxt : !pol_nxt;
  end
endmodule

// File: rtl/dreq_pulse_gen.sv
module dreq_pulse_gen
  import dreq_pkg::*;
#(
  parameter int PULSE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  output logic              dreq_o
);
  ctrl_t cur, nxt, wd;
  logic  start, run, done;

  assign wd  = ctrl_t'(reg_wdata);
  assign run = cur.trig && cur.mode;

  dreq_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(wd), .done(done),
    .cur(cur), .nxt(nxt), .start(start)
  );

  dreq_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start), .run(run), .done(done)
  );

  dreq_pin_drive u_pin (
    .clk(clk), .rst_n(rst_n), .trig_nxt(nxt.trig), .pol_nxt(nxt.pol), .pin(dreq_o)
  );

  assign reg_rdata = cur;

  AST_PIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    dreq_o == (cur.trig ? cur.pol : !cur.pol));  // R3
  AST_POL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !cur.trig && wd.pol && !wd.trig) |=> !dreq_o);  // R5
  AST_RETRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done && reg_wr && wd.trig && wd.mode) |=> (cur.trig && !start));  // R6
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.trig && !cur.mode && !(reg_wr && !wd.trig)) |=> cur.trig);  // R8
endmodule

// File: tb/sim_dreq_pulse_gen.sv
`timescale 1ns/1ps
module sim_dreq_pulse_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_wdata = 3'b000;
  logic [2:0] reg_rdata;
  logic       dreq_o;
  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  dreq_pulse_gen #(.PULSE_LEN(32)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dreq_o(dreq_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // Counts samples at the active level, starting at the sample after the trigger write.
  task automatic measure(input logic act, input int poke_at, input logic [2:0] poke_val,
                         input logic act_after, output int len);
    logic cur_act = act;
    len = 0;
    for (int i = 1; i <= 40; i++) begin
      if (dreq_o !== cur_act) break;
      len++;
      if (i == poke_at) begin reg_wr = 1'b1; reg_wdata = poke_val; end
      @(negedge clk);
      reg_wr = 1'b0;
      if (i == poke_at) cur_act = act_after;
    end
  endtask

  task automatic t_reset();
    chk("R1", "rdata after reset", int'(reg_rdata), 0);
    chk("R1", "pin after reset", int'(dreq_o), 1);
  endtask

  task automatic t_fields();
    wr(3'b010);
    chk("R2", "rdata pol only", int'(reg_rdata), 2);
    chk("R5", "pin low on pol write", int'(dreq_o), 0);
    wr(3'b100);
    chk("R2", "rdata mode only", int'(reg_rdata), 4);
    chk("R2", "pin high pol0 idle", int'(dreq_o), 1);
  endtask

  task automatic t_edge_low();
    int len;
    wr(3'b101);
    chk("R3", "pin low after trigger", int'(dreq_o), 0);
    chk("R2", "trigger reads 1", int'(reg_rdata[0]), 1);
    measure(1'b0, 0, 3'b000, 1'b0, len);
    chk("R4", "pulse length pol0", len, 32);
    chk("R4", "trigger clear at negate", int'(reg_rdata[0]), 0);
    chk("R4", "pin high after pulse", int'(dreq_o), 1);
  endtask

  task automatic t_edge_high();
    int len;
    wr(3'b110);
    chk("R5", "pin low after pol=1", int'(dreq_o), 0);
    wr(3'b111);
    measure(1'b1, 0, 3'b000, 1'b1, len);
    chk("R5", "pulse length pol1", len, 32);
    chk("R5", "pin idle low after pulse", int'(dreq_o), 0);
    chk("R4", "trigger cleared pol1", int'(reg_rdata[0]), 0);
    wr(3'b100);
    chk("R5", "pin high back to pol0", int'(dreq_o), 1);
  endtask

  task automatic t_retrig();
    int len;
    wr(3'b101);
    measure(1'b0, 20, 3'b101, 1'b0, len);
    chk("R6", "retrigger does not extend", len, 32);
    chk("R6", "trigger clear after", int'(reg_rdata[0]), 0);
  endtask

  task automatic t_write0();
    int len;
    wr(3'b101);
    measure(1'b0, 5, 3'b100, 1'b0, len);
    chk("R7", "write 0 keeps pulse", len, 32);
    chk("R7", "pin negated after", int'(dreq_o), 1);
  endtask

  task automatic t_level();
    wr(3'b001);
    chk("R8", "level assert", int'(dreq_o), 0);
    repeat (50) @(negedge clk);
    chk("R8", "level held past pulse length", int'(dreq_o), 0);
    chk("R8", "trigger still 1", int'(reg_rdata[0]), 1);
    wr(3'b000);
    chk("R8", "level cleared by write 0", int'(dreq_o), 1);
    chk("R8", "rdata zero", int'(reg_rdata), 0);
  endtask

  task automatic t_polflip();
    int len;
    wr(3'b101);
    measure(1'b0, 10, 3'b110, 1'b1, len);
    chk("R9", "length with pol flip", len, 32);
    chk("R9", "idle at pol1 level", int'(dreq_o), 0);
    chk("R9", "rdata after flip pulse", int'(reg_rdata), 6);
    wr(3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_edge_low();
    t_edge_high();
    t_retrig();
    t_write0();
    t_level();
    t_polflip();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule